// File: doc/BRIEF.md
# Multi-Port Memory Command Scheduler

This block sits in front of a single memory back end and decides which pending command goes out next. Each of its ports feeds a small private queue. A port is built as one of two kinds, chosen by a parameter bit. An in-order port acts as a simple bus bridge. An ID-tagged port labels each command with a thread ID. The scheduler may send commands out in a different order from their arrival, but only where the rules for that port kind allow it. Commands on different ports are never ordered against each other.

Among all commands that are legal to send, the scheduler picks the one with the highest score. The score is the number of cycles the command has waited. A fixed bonus is added when the command targets the same memory row as the command most recently placed in the issue register. The chosen command goes into a registered issue channel, which uses valid/ready handshaking.

Read data from the back end comes back tagged with a port number and a thread ID. The block steers it to that port through registered per-port valid strobes, together with the ID, the data and a last-beat flag. This lets a consumer put interleaved bursts back together.

Top module: `mem_cmd_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, `iss_valid` and every bit of `rd_valid` are 0, and every bit of `cmd_ready` is 1.
- R2: On an in-order port (bit p of ORDERED_MASK is 1), reads issue in the order they were accepted. Writes also issue in the order they were accepted.
- R3: On an in-order port, a write never issues before a read that the same port accepted earlier.
- R4: On an in-order port, a read may issue before a write that the same port accepted earlier. This happens when the read's score is higher.
- R5: On an ID-tagged port (bit p of ORDERED_MASK is 0), reads with equal thread IDs issue in the order they were accepted.
- R6: On an ID-tagged port, a read may issue ahead of an earlier read that has a different thread ID.
- R7: On an ID-tagged port, writes issue in the order they were accepted, whatever their thread IDs.
- R8: On an ID-tagged port, a read and a write may swap order only when their thread IDs differ and their word spans do not overlap. A command's span is [addr, addr+len].
- R9: A command may issue ahead of an older command that waits on a different port.
- R10: Each legal command gets a score. The score is its wait in cycles, saturating at 2^WW-1. BOOST is added when addr>>ROW_LSB equals the row of the command last loaded into the issue register. The highest score wins. On a tie, the lower port wins, then the lower slot.
- R11: While `iss_valid` is 1 and `iss_ready` is 0, the issue channel holds every field stable. A command can reach the issue channel one cycle after it is accepted, at the earliest.
- R12: A response with `rsp_valid`=1 and port p shows up on the next cycle as `rd_valid` with only bit p set. It carries the same ID, data and last flag. Without a response, `rd_valid` is 0.
- R13: A port's `cmd_ready` is 0 exactly when it holds DEPTH pending commands. When the back end accepts at least every other cycle, every accepted command issues within 200 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | NP | Command offered, one bit per port |
| cmd_ready | output | NP | Port queue has a free slot |
| cmd_wr | input | NP | 1 = write, 0 = read, per port |
| cmd_addr | input | NP*AW | Word address, port p at bits [p*AW +: AW] |
| cmd_len | input | NP*LW | Burst length minus one, per port |
| cmd_id | input | NP*IW | Thread ID, per port |
| iss_valid | output | 1 | Issue register holds a command |
| iss_ready | input | 1 | Back end takes the command |
| iss_wr | output | 1 | Direction of the issued command |
| iss_addr | output | AW | Address of the issued command |
| iss_len | output | LW | Length of the issued command |
| iss_id | output | IW | Thread ID of the issued command |
| iss_port | output | PW | Source port of the issued command |
| rsp_valid | input | 1 | Back end returns a read beat |
| rsp_port | input | PW | Destination port of the beat |
| rsp_id | input | IW | Thread ID of the beat |
| rsp_data | input | DW | Read data |
| rsp_last | input | 1 | Final beat of the burst |
| rd_valid | output | NP | Read beat valid, one bit per port |
| rd_id | output | IW | Thread ID of the delivered beat |
| rd_data | output | DW | Delivered data |
| rd_last | output | 1 | Final beat flag |

## Verification
Each scenario holds the back end stalled while one command sits in the issue register and a few more queue up behind it. The queued commands are laid out so that the row bonus pulls a younger command forward. The release order then shows whether a swap is legal or blocked. The scenarios cover a read passing a write on an in-order port, and a write held behind a read. They also cover reads with equal and with different IDs, writes with mixed IDs, read/write pairs with overlapping and with disjoint spans, and commands that cross ports. A long random sweep then mixes both ports, directions, lengths and IDs with a back end that is ready only some of the time. Every issue is checked against the ordering rules for all older pending commands on its port, and against the wait limit.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // 1 when a younger command must stay behind an older one of the same port
  function automatic logic must_wait(input logic ordered, input logic yng_wr,
                                     input logic old_wr, input logic same_id,
                                     input logic ovl);
    if (ordered)              return !(!yng_wr && old_wr);
    if (yng_wr && old_wr)     return 1'b1;
    if (!yng_wr && !old_wr)   return same_id;
    return same_id || ovl;
  endfunction

  // inclusive word spans [a0, a0+al] and [b0, b0+bl] share a word
  function automatic logic spans_meet(input logic [31:0] a0, input logic [31:0] al,
                                      input logic [31:0] b0, input logic [31:0] bl);
    logic [32:0] ae, be;
    ae = {1'b0, a0} + {1'b0, al};
    be = {1'b0, b0} + {1'b0, bl};
    return ({1'b0, a0} <= be) && ({1'b0, b0} <= ae);
  endfunction

endpackage

// File: rtl/sched_queue.sv
module sched_queue
  import sched_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int AW      = 16,
  parameter int LW      = 4,
  parameter int IW      = 2,
  parameter int WW      = 6,
  parameter bit ORDERED = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_wr,
  input  logic [AW-1:0]              in_addr,
  input  logic [LW-1:0]              in_len,
  input  logic [IW-1:0]              in_id,
  input  logic                       deq_en,
  input  logic [$clog2(DEPTH)-1:0]   deq_idx,
  output logic [DEPTH-1:0]           ent_ok,
  output logic [DEPTH-1:0]           ent_wr,
  output logic [DEPTH*AW-1:0]        ent_addr,
  output logic [DEPTH*LW-1:0]        ent_len,
  output logic [DEPTH*IW-1:0]        ent_id,
  output logic [DEPTH*WW-1:0]        ent_wait
);
  localparam int QW = $clog2(DEPTH);

  logic [DEPTH-1:0] vld, wr_q, blk;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [LW-1:0]    len_q  [DEPTH];
  logic [IW-1:0]    id_q   [DEPTH];
  logic [WW-1:0]    wait_q [DEPTH];
  logic [DEPTH-1:0] older  [DEPTH];   // older[i][j]: slot j arrived before slot i
  logic [QW-1:0]    free_idx;
  logic [DEPTH-1:0] deq_mask;
  logic             acc;

  always_comb begin
    free_idx = '0;
    in_ready = 1'b0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (!vld[k]) begin
        free_idx = QW'(k);
        in_ready = 1'b1;
      end
    end
  end

  assign acc      = in_valid && in_ready;
  assign deq_mask = deq_en ? (DEPTH'(1) << deq_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) older[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (vld[i] && (wait_q[i] != {WW{1'b1}})) wait_q[i] <= wait_q[i] + 1'b1;
      if (deq_en) begin
        vld[deq_idx] <= 1'b0;
        for (int i = 0; i < DEPTH; i++) older[i][deq_idx] <= 1'b0;
      end
      if (acc) begin
        vld[free_idx]    <= 1'b1;
        wr_q[free_idx]   <= in_wr;
        addr_q[free_idx] <= in_addr;
        len_q[free_idx]  <= in_len;
        id_q[free_idx]   <= in_id;
        wait_q[free_idx] <= '0;
        older[free_idx]  <= vld & ~deq_mask;
      end
    end
  end

  // ordering legality against every older pending entry
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      blk[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (vld[j] && older[i][j])
          blk[i] = blk[i] | must_wait(ORDERED, wr_q[i], wr_q[j], id_q[i] == id_q[j],
                     spans_meet(32'(addr_q[i]), 32'(len_q[i]), 32'(addr_q[j]), 32'(len_q[j])));
      end
      ent_ok[i] = vld[i] && !blk[i];
      ent_wr[i] = wr_q[i];
      ent_addr[i*AW +: AW] = addr_q[i];
      ent_len[i*LW +: LW]  = len_q[i];
      ent_id[i*IW +: IW]   = id_q[i];
      ent_wait[i*WW +: WW] = wait_q[i];
    end
  end

  AST_DEQ_LEGAL: assert property (@(posedge clk) disable iff (rst)
    deq_en |-> (vld[deq_idx] && ent_ok[deq_idx])); // R2
  AST_FILL_COUNT: assert property (@(posedge clk) disable iff (rst)
    (acc && !deq_en) |=> ($countones(vld) == $past($countones(vld)) + 1)); // R13

endmodule

// File: rtl/mem_cmd_sched.sv
module mem_cmd_sched #(
  parameter int          NP           = 2,
  parameter int          DEPTH        = 4,
  parameter int          AW           = 16,
  parameter int          LW           = 4,
  parameter int          IW           = 2,
  parameter int          DW           = 16,
  parameter int          WW           = 6,
  parameter int          ROW_LSB      = 8,
  parameter int          BOOST        = 4,
  parameter logic [NP-1:0] ORDERED_MASK = 2'b01
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NP-1:0]                        cmd_valid,
  output logic [NP-1:0]                        cmd_ready,
  input  logic [NP-1:0]                        cmd_wr,
  input  logic [NP*AW-1:0]                     cmd_addr,
  input  logic [NP*LW-1:0]                     cmd_len,
  input  logic [NP*IW-1:0]                     cmd_id,
  output logic                                 iss_valid,
  input  logic                                 iss_ready,
  output logic                                 iss_wr,
  output logic [AW-1:0]                        iss_addr,
  output logic [LW-1:0]                        iss_len,
  output logic [IW-1:0]                        iss_id,
  output logic [((NP > 1) ? $clog2(NP) : 1)-1:0] iss_port,
  input  logic                                 rsp_valid,
  input  logic [((NP > 1) ? $clog2(NP) : 1)-1:0] rsp_port,
  input  logic [IW-1:0]                        rsp_id,
  input  logic [DW-1:0]                        rsp_data,
  input  logic                                 rsp_last,
  output logic [NP-1:0]                        rd_valid,
  output logic [IW-1:0]                        rd_id,
  output logic [DW-1:0]                        rd_data,
  output logic                                 rd_last
);
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;
  localparam int QW = $clog2(DEPTH);
  localparam int RW = AW - ROW_LSB;
  localparam int SW = WW + $clog2(BOOST + 1) + 1;

  logic [DEPTH-1:0]       q_ok   [NP];
  logic [DEPTH-1:0]       q_wr   [NP];
  logic [DEPTH*AW-1:0]    q_addr [NP];
  logic [DEPTH*LW-1:0]    q_len  [NP];
  logic [DEPTH*IW-1:0]    q_id   [NP];
  logic [DEPTH*WW-1:0]    q_wait [NP];
  logic [NP-1:0]          q_deq;

  logic                   best_any, load;
  logic [PW-1:0]          best_p;
  logic [QW-1:0]          best_e;
  logic [SW-1:0]          best_s, cand_s;
  logic [RW-1:0]          last_row;
  logic                   sel_wr;
  logic [AW-1:0]          sel_addr;
  logic [LW-1:0]          sel_len;
  logic [IW-1:0]          sel_id;

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign q_deq[p] = load && (best_p == PW'(p));
    sched_queue #(
      .DEPTH(DEPTH), .AW(AW), .LW(LW), .IW(IW), .WW(WW), .ORDERED(ORDERED_MASK[p])
    ) u_queue (
      .clk(clk), .rst(rst),
      .in_valid(cmd_valid[p]), .in_ready(cmd_ready[p]), .in_wr(cmd_wr[p]),
      .in_addr(cmd_addr[p*AW +: AW]), .in_len(cmd_len[p*LW +: LW]), .in_id(cmd_id[p*IW +: IW]),
      .deq_en(q_deq[p]), .deq_idx(best_e),
      .ent_ok(q_ok[p]), .ent_wr(q_wr[p]), .ent_addr(q_addr[p]), .ent_len(q_len[p]),
      .ent_id(q_id[p]), .ent_wait(q_wait[p])
    );
  end

  // oldest legal command wins, row hits get a bonus
  always_comb begin
    best_any = 1'b0;
    best_p   = '0;
    best_e   = '0;
    best_s   = '0;
    for (int p = 0; p < NP; p++) begin
      for (int e = 0; e < DEPTH; e++) begin
        cand_s = SW'(q_wait[p][e*WW +: WW]);
        if (q_addr[p][e*AW + ROW_LSB +: RW] == last_row) cand_s = cand_s + SW'(BOOST);
        if (q_ok[p][e] && (!best_any || cand_s > best_s)) begin
          best_any = 1'b1;
          best_p   = PW'(p);
          best_e   = QW'(e);
          best_s   = cand_s;
        end
      end
    end
    sel_wr   = q_wr[best_p][best_e];
    sel_addr = q_addr[best_p][best_e*AW +: AW];
    sel_len  = q_len[best_p][best_e*LW +: LW];
    sel_id   = q_id[best_p][best_e*IW +: IW];
  end

  assign load = best_any && (!iss_valid || iss_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      last_row  <= '0;
    end else if (load) begin
      iss_valid <= 1'b1;
      iss_wr    <= sel_wr;
      iss_addr  <= sel_addr;
      iss_len   <= sel_len;
      iss_id    <= sel_id;
      iss_port  <= best_p;
      last_row  <= sel_addr[AW-1:ROW_LSB];
    end else if (iss_ready) begin
      iss_valid <= 1'b0;
    end
  end

  // read data steering
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= '0;
    end else begin
      for (int p = 0; p < NP; p++) rd_valid[p] <= rsp_valid && (rsp_port == PW'(p));
    end
    rd_id   <= rsp_id;
    rd_data <= rsp_data;
    rd_last <= rsp_last;
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_addr) && $stable(iss_port)
                                   && $stable(iss_wr) && $stable(iss_id) && $stable(iss_len))); // R11
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_valid)); // R12
  AST_RD_ROUTE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (rd_valid[$past(rsp_port)] && rd_data == $past(rsp_data))); // R12

endmodule

// File: tb/mem_cmd_sched_bench.sv
`timescale 1ns/1ps
module mem_cmd_sched_bench;
  localparam int NP = 2, AW = 16, LW = 4, IW = 2, DW = 16;
  localparam int AGE_LIMIT = 200;
  localparam int MAXC = 1024;

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0] cmd_valid = '0, cmd_wr = '0;
  logic [NP*AW-1:0] cmd_addr = '0;
  logic [NP*LW-1:0] cmd_len = '0;
  logic [NP*IW-1:0] cmd_id = '0;
  logic [NP-1:0] cmd_ready, rd_valid;
  logic iss_valid, iss_ready = 1'b0, iss_wr, rd_last;
  logic [AW-1:0] iss_addr;
  logic [LW-1:0] iss_len;
  logic [IW-1:0] iss_id, rd_id;
  logic [0:0] iss_port, rsp_port = '0;
  logic rsp_valid = 1'b0, rsp_last = 1'b0;
  logic [IW-1:0] rsp_id = '0;
  logic [DW-1:0] rsp_data = '0, rd_data;

  always #2.5 clk = ~clk;

  mem_cmd_sched u_mem_cmd_sched (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_id(cmd_id),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_wr(iss_wr), .iss_addr(iss_addr),
    .iss_len(iss_len), .iss_id(iss_id), .iss_port(iss_port),
    .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .rd_valid(rd_valid), .rd_id(rd_id), .rd_data(rd_data), .rd_last(rd_last)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_cmd = 0, n_iss = 0, n_log = 0;
  int c_port [MAXC], c_addr [MAXC], c_len [MAXC], c_id [MAXC], c_acc [MAXC];
  bit c_wr [MAXC], c_done [MAXC];
  int l_addr [MAXC];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ordering rules as stated in the requirements; port 0 in-order, port 1 ID-tagged
  function automatic bit held_back(int port, bit yw, bit ow, bit sid, bit ovl);
    if (port == 0) return (yw && ow) || (!yw && !ow) || (yw && !ow);
    if (yw && ow) return 1'b1;
    if (!yw && !ow) return sid;
    return sid || ovl;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: one negedge before the edge where handshakes take effect
  always @(negedge clk) begin
    if (!rst) begin
      if (iss_valid && iss_ready) begin
        int k;
        bit legal;
        k = -1;
        for (int i = 0; i < n_cmd; i++)
          if (k < 0 && !c_done[i] && c_port[i] == int'(iss_port) && c_addr[i] == int'(iss_addr)) k = i;
        chk(k >= 0, "R13 issued command was accepted", iss_addr, 0);
        if (k >= 0) begin
          legal = 1'b1;
          for (int e = 0; e < k; e++) begin
            if (!c_done[e] && c_port[e] == c_port[k]) begin
              bit ovl;
              ovl = (c_addr[k] <= c_addr[e] + c_len[e]) && (c_addr[e] <= c_addr[k] + c_len[k]);
              if (held_back(c_port[k], c_wr[k], c_wr[e], c_id[k] == c_id[e], ovl)) legal = 1'b0;
            end
          end
          chk(legal, (c_port[k] == 0) ? "R2 R3 in-order legality" : "R5 R7 R8 id-port legality",
              c_addr[k], 0);
          chk(cyc - c_acc[k] <= AGE_LIMIT, "R13 wait limit", cyc - c_acc[k], AGE_LIMIT);
          c_done[k] = 1'b1;
          n_iss++;
          l_addr[n_log] = c_addr[k];
          n_log++;
        end
      end
      for (int p = 0; p < NP; p++) begin
        if (cmd_valid[p] && cmd_ready[p]) begin
          c_port[n_cmd] = p;
          c_wr[n_cmd]   = cmd_wr[p];
          c_addr[n_cmd] = int'(cmd_addr[p*AW +: AW]);
          c_len[n_cmd]  = int'(cmd_len[p*LW +: LW]);
          c_id[n_cmd]   = int'(cmd_id[p*IW +: IW]);
          c_acc[n_cmd]  = cyc;
          c_done[n_cmd] = 1'b0;
          n_cmd++;
        end
      end
    end
  end

  // called at posedge+1; returns at posedge+1 after the handshake edge
  task automatic push(input int p, input bit w, input int a, input int l, input int id);
    cmd_valid[p] = 1'b1;
    cmd_wr[p] = w;
    cmd_addr[p*AW +: AW] = AW'(a);
    cmd_len[p*LW +: LW] = LW'(l);
    cmd_id[p*IW +: IW] = IW'(id);
    forever begin
      @(negedge clk);
      if (cmd_ready[p]) break;
      @(posedge clk); #1 iss_ready = 1'b1;
    end
    @(posedge clk); #1 cmd_valid[p] = 1'b0;
  endtask

  task automatic drain();
    iss_ready = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (n_iss == n_cmd && !iss_valid) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic chk_seq(input string req, input int st, input int n,
                         input int e0, input int e1, input int e2, input int e3, input int e4);
    int e [5];
    e = '{e0, e1, e2, e3, e4};
    for (int i = 0; i < n; i++) chk(l_addr[st + i] == e[i], req, l_addr[st + i], e[i]);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", cyc, 200000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int st;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!iss_valid, "R1 iss_valid in reset", iss_valid, 0);
    chk(cmd_ready == 2'b11, "R1 cmd_ready in reset", cmd_ready, 2'b11);
    chk(rd_valid == 2'b00, "R1 rd_valid in reset", rd_valid, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(!iss_valid && cmd_ready == 2'b11, "R1 after reset", {iss_valid, cmd_ready}, 3'b011);
    @(posedge clk); #1;

    // R4: read passes earlier write on the in-order port via the row bonus
    st = n_log; iss_ready = 1'b0;
    push(0, 0, 'h0100, 0, 0); push(0, 1, 'h0210, 0, 0); push(0, 0, 'h0120, 0, 0);
    @(negedge clk);
    chk(iss_valid && iss_addr == 'h0100, "R11 held while stalled", iss_addr, 'h0100);
    @(posedge clk); #1 drain();
    chk_seq("R4 read before older write", st, 3, 'h0100, 'h0120, 'h0210, 0, 0);

    // R3: write may not pass earlier read even with the bonus
    st = n_log; iss_ready = 1'b0;
    push(0, 0, 'h0300, 0, 0); push(0, 0, 'h0400, 0, 0); push(0, 1, 'h0310, 0, 0);
    drain();
    chk_seq("R3 write behind read", st, 3, 'h0300, 'h0400, 'h0310, 0, 0);

    // R5/R6: reads on the ID port
    st = n_log; iss_ready = 1'b0;
    push(1, 0, 'h0500, 0, 1); push(1, 0, 'h0600, 0, 0);
    push(1, 0, 'h0510, 0, 2); push(1, 0, 'h0520, 0, 0);
    drain();
    chk_seq("R6 R5 id read order", st, 4, 'h0500, 'h0510, 'h0600, 'h0520, 0);

    // R7: writes with mixed IDs stay in order
    st = n_log; iss_ready = 1'b0;
    push(1, 1, 'h0700, 0, 0); push(1, 1, 'h0800, 0, 1); push(1, 1, 'h0710, 0, 2);
    drain();
    chk_seq("R7 id write order", st, 3, 'h0700, 'h0800, 'h0710, 0, 0);

    // R8: disjoint read passes write, overlapping read does not
    st = n_log; iss_ready = 1'b0;
    push(1, 0, 'h0900, 0, 0); push(1, 1, 'h0a00, 3, 1); push(1, 0, 'h0902, 0, 2);
    drain();
    chk_seq("R8 disjoint swap", st, 3, 'h0900, 'h0902, 'h0a00, 0, 0);
    st = n_log; iss_ready = 1'b0;
    push(1, 0, 'h0b80, 0, 0); push(1, 1, 'h0afe, 3, 1); push(1, 0, 'h0b01, 0, 2);
    drain();
    chk_seq("R8 overlap blocks swap", st, 3, 'h0b80, 'h0afe, 'h0b01, 0, 0);

    // R9: younger command of another port passes
    st = n_log; iss_ready = 1'b0;
    push(0, 0, 'h0d00, 0, 0); push(0, 1, 'h0e00, 0, 0); push(1, 0, 'h0d10, 0, 0);
    drain();
    chk_seq("R9 cross-port pass", st, 3, 'h0d00, 'h0d10, 'h0e00, 0, 0);

    // R10: without bonus the oldest wins, whatever its port
    st = n_log; iss_ready = 1'b0;
    push(0, 0, 'h1000, 0, 0); push(1, 1, 'h2000, 0, 0); push(0, 1, 'h3000, 0, 0);
    drain();
    chk_seq("R10 oldest first", st, 3, 'h1000, 'h2000, 'h3000, 0, 0);
    st = n_log; iss_ready = 1'b0;
    push(0, 0, 'h1100, 0, 0); push(0, 1, 'h3100, 0, 0); push(1, 1, 'h2100, 0, 0);
    drain();
    chk_seq("R10 oldest first reversed", st, 3, 'h1100, 'h3100, 'h2100, 0, 0);

    // R13: full queue deasserts ready on that port only
    st = n_log; iss_ready = 1'b0;
    push(0, 0, 'h5000, 0, 0);
    for (int i = 1; i <= 4; i++) push(0, 0, 'h5000 + 16 * i, 0, 0);
    @(negedge clk);
    chk(cmd_ready == 2'b10, "R13 full port not ready", cmd_ready, 2'b10);
    chk(iss_valid && iss_addr == 'h5000, "R11 stalled issue held", iss_addr, 'h5000);
    @(posedge clk); #1 drain();
    chk_seq("R2 reads in order", st, 5, 'h5000, 'h5010, 'h5020, 'h5030, 'h5040);

    // R12: response steering
    rsp_valid = 1'b1; rsp_port = 1'b1; rsp_id = 2'd2; rsp_data = 16'hbeef; rsp_last = 1'b1;
    @(posedge clk); #1 rsp_port = 1'b0; rsp_id = 2'd1; rsp_data = 16'h1234; rsp_last = 1'b0;
    @(negedge clk);
    chk(rd_valid == 2'b10 && rd_id == 2'd2 && rd_data == 16'hbeef && rd_last,
        "R12 route port1", {rd_valid, rd_id, rd_data, rd_last}, {2'b10, 2'd2, 16'hbeef, 1'b1});
    @(posedge clk); #1 rsp_valid = 1'b0;
    @(negedge clk);
    chk(rd_valid == 2'b01 && rd_id == 2'd1 && rd_data == 16'h1234 && !rd_last,
        "R12 route port0", {rd_valid, rd_id, rd_data, rd_last}, {2'b01, 2'd1, 16'h1234, 1'b0});
    @(posedge clk); #1;
    @(negedge clk);
    chk(rd_valid == 2'b00, "R12 idle", rd_valid, 0);
    @(posedge clk); #1;

    // random sweep: legality and wait limit checked by the monitor
    for (int s = 0; s < 300; s++) begin
      iss_ready = ($urandom % 2) == 0;
      push($urandom % 2, $urandom % 2, 'h6000 + 5 * s, $urandom % 4, $urandom % 4);
    end
    drain();
    chk(n_iss == n_cmd, "R13 all accepted commands issued", n_iss, n_cmd);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule